// File: doc/BRIEF.md
# Aligned DMA Serial Receive Engine

This block is the receive-to-memory path of a serial channel. Software programs a destination address and a byte count, then writes a control word that asks for a DMA read. The engine then pulls bytes from the serial device one at a time through a valid/ready handshake. It packs them big-endian into 32-bit words and writes each word to system memory through a valid/ready write port. Words are grouped into 32-byte blocks. The start bit stays set while the transfer runs and clears itself when memory accepts the final word, which is how software learns that the transfer is complete.

Address and count must both be multiples of the block size. A request that breaks this rule raises an error flag and finishes without touching memory. A count of zero finishes at once. When memory stalls, the engine stops asking for bytes, so the serial side is held and no byte is lost. Device selection and serial clock rate are set outside this block.

Top module: `dma_rx_engine`

## Requirements
- R1: After reset, busy, align_err, mem_valid and rx_ready are all low.
- R2: cfg_sel 1 writes the address, cfg_sel 2 writes the byte count and cfg_sel 3 writes control. In control, bit 0 is start, bit 1 is DMA enable and bits 3:2 are direction, where 0 means read. A control write with start=1, DMA=1 and direction=0 sets busy in the cycle after the write.
- R3: A control write whose DMA enable is 0, or whose direction is not 0, leaves busy and rx_ready low.
- R4: Bytes are packed big-endian: the first byte of each group of four lands in mem_data bits 31:24 and the fourth lands in bits 7:0.
- R5: Word j of a transfer is written at base + 4*j. mem_last is high on the eighth word of every 32-byte block.
- R6: For a valid non-empty transfer, busy stays high until the clock edge at which memory accepts the final word, and it is low from the next cycle on.
- R7: If the low 5 bits of the address or the count are non-zero, busy is high for exactly one cycle, align_err is then set, and no byte is requested and no memory write is made.
- R8: A count of zero keeps busy high for exactly one cycle, with align_err low and no memory write.
- R9: While mem_valid is high and mem_ready is low, mem_valid, mem_addr and mem_data hold their values and rx_ready is low. Every offered byte appears in memory exactly once.
- R10: Address, count and control writes made while busy is high have no effect on the running transfer.
- R11: align_err clears when the next transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 1 address, 2 count, 3 control |
| cfg_wdata | input | 32 | Configuration write data |
| busy | output | 1 | Start bit; high while a transfer is in progress |
| align_err | output | 1 | Set when the last request broke the alignment rule |
| rx_valid | input | 1 | Serial side offers a byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Engine takes the byte; low stalls the serial clock |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Byte address of the word being written |
| mem_data | output | 32 | Packed word |
| mem_last | output | 1 | Final word of a 32-byte block |

## Verification
Busy rises on the first edge after the accepted control write. For a misaligned or empty request it falls on the second edge, at the same moment align_err takes its final value. A packed word appears on mem_valid on the edge that captures its fourth byte, and busy falls on the very edge at which memory takes the final word. The bench drives all inputs and samples all outputs on the falling clock edge. It decides each handshake from values that are already settled, so it knows which edge a byte or word transfers on. It then checks the busy window in whole cycles against those edges.

// File: rtl/dma_rx_pkg.sv
package dma_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } dma_state_e;

  // register select codes (word offsets within the channel)
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_LEN  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // control word fields
  localparam int         CTL_START = 0;
  localparam int         CTL_DMA   = 1;
  localparam int         CTL_DIR_L = 2;
  localparam logic [1:0] DIR_READ  = 2'b00;

  localparam int WORD_BYTES = 4;

endpackage

// File: rtl/dma_rx_cfg.sv
module dma_rx_cfg
  import dma_rx_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              launch_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              wr_ok;

  assign wr_ok = cfg_we && !busy;

  always_comb begin
    addr_d   = addr_q;
    len_d    = len_q;
    launch_o = 1'b0;
    if (wr_ok) begin
      case (cfg_sel)
        SEL_ADDR: addr_d = cfg_wdata[ADDR_W-1:0];
        SEL_LEN:  len_d  = cfg_wdata[LEN_W-1:0];
        SEL_CTRL: launch_o = cfg_wdata[CTL_START] && cfg_wdata[CTL_DMA] &&
                             (cfg_wdata[CTL_DIR_L+1:CTL_DIR_L] == DIR_READ);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (wr_ok) begin
      addr_q <= addr_d;
      len_q  <= len_d;
    end
  end

  assign addr_o = addr_q;
  assign len_o  = len_q;

  // R10: configuration stays frozen while a transfer runs
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy -> ($stable(addr_q) && $stable(len_q))));

endmodule

// File: rtl/dma_rx_pack.sv
module dma_rx_pack
  import dma_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        take,
  input  logic [7:0]  byte_i,
  input  logic        ack,
  output logic        valid_o,
  output logic [31:0] word_o
);

  logic [1:0]  lane_q, lane_d;
  logic [31:0] shift_q, shift_d;
  logic        valid_q, valid_d;
  logic        en;

  assign en = clr || take || ack;

  always_comb begin
    lane_d  = lane_q;
    shift_d = shift_q;
    valid_d = valid_q;
    if (clr) begin
      lane_d  = '0;
      valid_d = 1'b0;
    end else begin
      if (take) begin
        shift_d = {shift_q[23:0], byte_i};
        lane_d  = lane_q + 2'd1;
        if (lane_q == 2'd3) valid_d = 1'b1;
      end
      if (ack) valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q  <= '0;
      shift_q <= '0;
      valid_q <= 1'b0;
    end else if (en) begin
      lane_q  <= lane_d;
      shift_q <= shift_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;
  assign word_o  = shift_q;

  // R9: a pending word is never overwritten by a new byte
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !valid_q);

endmodule

// File: rtl/dma_rx_addr.sv
module dma_rx_addr
  import dma_rx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  localparam int ALIGN  = $clog2(BURST_BYTES);
  localparam int BEATS  = BURST_BYTES / WORD_BYTES;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int BLK_W  = ADDR_W - ALIGN;

  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              end_of_blk;

  assign end_of_blk = (beat_q == BEAT_W'(BEATS - 1));

  always_comb begin
    blk_d  = blk_q;
    beat_d = beat_q;
    if (load) begin
      blk_d  = base_i[ADDR_W-1:ALIGN];
      beat_d = '0;
    end else if (adv) begin
      if (end_of_blk) begin
        blk_d  = blk_q + BLK_W'(1);
        beat_d = '0;
      end else begin
        beat_d = beat_q + BEAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      beat_q <= '0;
    end else if (load || adv) begin
      blk_q  <= blk_d;
      beat_q <= beat_d;
    end
  end

  assign addr_o = {blk_q, beat_q, 2'b00};
  assign last_o = end_of_blk;

  // R5: inside a block the address steps by one word
  a_r5_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && !last_o) |=> (addr_o == $past(addr_o) + ADDR_W'(WORD_BYTES)));

  // R5: after the final beat the next block starts aligned
  a_r5_block_align: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && last_o) |=> (addr_o[ALIGN-1:0] == '0));

endmodule

// File: rtl/dma_rx_engine.sv
module dma_rx_engine
  import dma_rx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              busy,
  output logic              align_err,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              mem_last
);

  localparam int ALIGN = $clog2(BURST_BYTES);

  dma_state_e        state_q, state_d;
  logic              busy_q, busy_d;
  logic              err_q, err_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [ADDR_W-1:0] cfg_addr;
  logic [LEN_W-1:0]  cfg_len;
  logic              launch;
  logic              take;
  logic              ack;
  logic              word_valid;
  logic              misaligned;

  dma_rx_cfg #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .busy     (busy_q),
    .addr_o   (cfg_addr),
    .len_o    (cfg_len),
    .launch_o (launch)
  );

  dma_rx_pack i_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (launch),
    .take   (take),
    .byte_i (rx_data),
    .ack    (ack),
    .valid_o(word_valid),
    .word_o (mem_data)
  );

  dma_rx_addr #(.ADDR_W(ADDR_W), .BURST_BYTES(BURST_BYTES)) i_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (launch),
    .base_i(cfg_addr),
    .adv   (ack),
    .addr_o(mem_addr),
    .last_o(mem_last)
  );

  assign misaligned = (|cfg_addr[ALIGN-1:0]) || (|cfg_len[ALIGN-1:0]);
  assign rx_ready   = (state_q == ST_RUN) && (left_q != '0) && !word_valid;
  assign take       = rx_valid && rx_ready;
  assign mem_valid  = word_valid;
  assign ack        = word_valid && mem_ready;

  always_comb begin
    state_d = state_q;
    busy_d  = busy_q;
    err_d   = err_q;
    left_d  = left_q;
    case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_CHECK;
          busy_d  = 1'b1;
          err_d   = 1'b0;
        end
      end
      ST_CHECK: begin
        if (misaligned) begin
          err_d   = 1'b1;
          busy_d  = 1'b0;
          state_d = ST_IDLE;
        end else if (cfg_len == '0) begin
          busy_d  = 1'b0;
          state_d = ST_IDLE;
        end else begin
          left_d  = cfg_len;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (take) left_d = left_q - LEN_W'(1);
        if (ack && (left_q == '0)) begin
          busy_d  = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        busy_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
      err_q   <= err_d;
      left_q  <= left_d;
    end
  end

  assign busy      = busy_q;
  assign align_err = err_q;

  // R9: a stalled write holds address and data
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data) && $stable(mem_addr)));

  // R6: busy falls only after the check step or a memory acceptance
  a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(state_q == ST_CHECK) || $past(mem_valid && mem_ready)));

  // R7: an alignment error leaves the engine idle and silent
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!busy && !mem_valid && !rx_ready));

  // R2: a fresh transfer starts with nothing pending
  a_r2_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!mem_valid && !rx_ready));

  // R3: memory writes happen only inside a transfer
  a_r3_write_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

endmodule

// File: tb/test_dma_rx_engine.sv
`timescale 1ns/1ps
module test_dma_rx_engine;

  localparam int NV = 7;
  localparam logic [31:0] V_ADDR [NV] = '{32'h1000, 32'h2040, 32'h0FE0, 32'h3004,
                                          32'h4000, 32'h0100, 32'h5000};
  localparam int          V_LEN  [NV] = '{32, 96, 64, 32, 40, 0, 32};
  localparam logic [7:0]  V_SEED [NV] = '{8'h10, 8'hA0, 8'h33, 8'h00, 8'h00, 8'h00, 8'hF0};
  localparam int          V_MODE [NV] = '{0, 1, 2, 0, 0, 0, 1};
  localparam bit          V_POKE [NV] = '{0, 0, 1, 0, 0, 0, 0};
  localparam bit          V_ERR  [NV] = '{0, 0, 0, 1, 1, 0, 0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        busy, align_err;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        mem_valid, mem_ready;
  logic [31:0] mem_addr, mem_data;
  logic        mem_last;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_rx_engine i_dma_rx_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .busy(busy), .align_err(align_err), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_last(mem_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] exp_word(input logic [7:0] seed, input int w);
    logic [7:0] b0 = seed + 8'(4*w);
    return {b0, b0 + 8'd1, b0 + 8'd2, b0 + 8'd3};
  endfunction

  task automatic run_vec(input int v);
    int nbytes = 0;
    int nwords = 0;
    int c = 0;
    int last_ack = -10;
    int exp_words;
    bit rv, mr;
    exp_words = V_ERR[v] ? 0 : V_LEN[v] / 4;
    cfg_write(2'd1, V_ADDR[v]);
    cfg_write(2'd2, 32'(V_LEN[v]));
    cfg_write(2'd3, 32'h3);
    chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
    chk(align_err == 1'b0, "R11 err cleared at start", 32'(align_err), 0);
    while (busy) begin
      case (V_MODE[v])
        1: begin rv = (c % 2) == 0; mr = (c % 3) == 2; end
        2: begin rv = 1'b1;         mr = (c % 4) < 2;  end
        default: begin rv = 1'b1;   mr = 1'b1;         end
      endcase
      rx_valid  = rv && (nbytes < V_LEN[v]);
      rx_data   = V_SEED[v] + 8'(nbytes);
      if (rx_valid && rx_ready) nbytes++;
      mem_ready = mr;
      if (mem_valid && mr) begin
        chk(mem_data == exp_word(V_SEED[v], nwords), "R4 packed word", mem_data,
            exp_word(V_SEED[v], nwords));
        chk(mem_addr == V_ADDR[v] + 32'(4*nwords), "R5 word address", mem_addr,
            V_ADDR[v] + 32'(4*nwords));
        chk(mem_last == ((nwords % 8) == 7), "R5 block last", 32'(mem_last),
            32'((nwords % 8) == 7));
        nwords++;
        last_ack = c;
      end
      if (V_POKE[v] && c == 6) begin
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h0000_ABC0;  // R10 poke
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
      c++;
      if (c > 5000) begin
        chk(1'b0, "R6 transfer hung", 32'(c), 0);
        break;
      end
    end
    rx_valid = 1'b0; mem_ready = 1'b0; cfg_we = 1'b0;
    chk(nwords == exp_words, "R9 word count", 32'(nwords), 32'(exp_words));
    chk(align_err == V_ERR[v], "R7 error flag", 32'(align_err), 32'(V_ERR[v]));
    if (exp_words == 0) begin
      chk(c == 1, V_ERR[v] ? "R7 one-cycle busy" : "R8 one-cycle busy", 32'(c), 1);
      chk(nbytes == 0, V_ERR[v] ? "R7 no byte taken" : "R8 no byte taken", 32'(nbytes), 0);
    end else begin
      chk(last_ack == c - 1, "R6 busy falls after final write", 32'(last_ack), 32'(c - 1));
      chk(nbytes == V_LEN[v], "R9 bytes taken", 32'(nbytes), 32'(V_LEN[v]));
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    rx_valid = 1'b0; rx_data = '0; mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(align_err == 1'b0, "R1 err", 32'(align_err), 0);
    chk(mem_valid == 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
    chk(rx_ready == 1'b0, "R1 rx_ready", 32'(rx_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R3: start without DMA enable, then DMA with write direction
    cfg_write(2'd1, 32'h6000);
    cfg_write(2'd2, 32'd32);
    cfg_write(2'd3, 32'h1);
    chk(busy == 1'b0, "R3 no-dma busy", 32'(busy), 0);
    @(negedge clk);
    chk(rx_ready == 1'b0, "R3 no-dma rx_ready", 32'(rx_ready), 0);
    cfg_write(2'd3, 32'h7);
    chk(busy == 1'b0, "R3 write-dir busy", 32'(busy), 0);
    @(negedge clk);
    chk(busy == 1'b0 && rx_ready == 1'b0, "R3 write-dir idle",
        32'({busy, rx_ready}), 0);

    // R1: reset in mid-transfer returns to idle
    cfg_write(2'd3, 32'h3);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && mem_valid == 1'b0, "R1 reset mid-run",
        32'({busy, mem_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule